// File: doc/BRIEF.md
# Multi-Link Stream Read Unit

This unit carries out a processor's "read one word from a stream" operation, with the link chosen at run time. A command brings a four-bit link index and five mode bits, and also a user-mode flag. The mode bits are: non-blocking, expected control value, exception enable, test (peek without consuming) and atomic.

The unit selects one of up to 16 stream slave links and waits for data or completes at once, depending on the mode. It compares the link's TLAST bit with the expected control value. It then publishes a destination word with a write strobe, a carry flag and a sticky stream-error flag. It also publishes exception outputs (cause code, link field, captured data) and an atomic flag that tells the interrupt logic to hold off for the next instruction.

The stream side is valid/ready, and this unit is the sink. Back-pressure is the unit's choice alone. TREADY is low on every link except the selected one, and on that link it is high for a single cycle: the cycle in which the unit takes the word. A link may present TVALID for as long as it likes without the unit taking anything. The command side uses a plain start pulse, a `busy` level and a one-cycle `done` pulse. The result outputs are valid when `done` is high and keep their values until the next completion.

Top module: `strm_get_unit`

## Requirements
- R1: The selected link is the four-bit `idx` when `idx` < LINKS, and link 0 otherwise. On completion without an exception, `rd_data` holds the TDATA word of the selected link and `rd_we` is 1.
- R2: In blocking mode (`mode_n`=0) the unit keeps `busy` high and does not complete while the selected link's TVALID is low. In the cycle that TVALID is seen, TREADY is raised for exactly one cycle on that link only, and every other TREADY stays 0.
- R3: In non-blocking mode (`mode_n`=1) the operation completes without waiting, and `carry` becomes 0 if TVALID was 1 and 1 if it was 0. A blocking operation leaves `carry` unchanged.
- R4: A completed operation with TVALID=1 and TLAST different from `mode_c` sets `strm_err`. The flag stays set until a cycle with `err_clr`=1, and it is then 0 unless a new mismatch is being published in that same cycle.
- R5: With EXC_EN=1 and `mode_e`=1, a control mismatch completes with `exc`=1, `exc_cause`=5'b00000, `exc_link` equal to the raw four-bit `idx`, and `exc_data` equal to the link word. In that case `rd_we`=0 and `rd_data` is unchanged.
- R6: With `mode_t`=1 the operation completes with the same results, but TREADY stays 0 on all links.
- R7: With PRIV_EN=1 and `user_mode`=1, no TREADY is raised and the operation completes at once with `exc`=1, `exc_cause`=5'b00111 and `rd_we`=0. `carry`, `strm_err`, `exc_link` and `exc_data` are unchanged.
- R8: `done` rises one cycle after the accepting start edge when the operation can complete at once (AREA_OPT=0), and two cycles after it with AREA_OPT=1, with identical results.
- R9: `atomic_hold` equals `mode_a` of the most recently completed operation.
- R10: A start pulse while `busy` is 1 is ignored. `done` is a one-cycle pulse. `rd_data` changes only in a cycle where `done` is 1.
- R11: After reset, `busy`, `done`, every TREADY and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken only when not busy |
| idx | input | 4 | Link index operand |
| mode_n | input | 1 | 1 = non-blocking |
| mode_c | input | 1 | Expected TLAST value |
| mode_e | input | 1 | Raise exception on control mismatch |
| mode_t | input | 1 | Test read, data not consumed |
| mode_a | input | 1 | Atomic operation |
| user_mode | input | 1 | Issuing code runs in user mode |
| err_clr | input | 1 | Clear the sticky stream-error flag |
| s_tdata | input | LINKS*DW | TDATA of all links, link k at bits k*DW upward |
| s_tvalid | input | LINKS | TVALID per link |
| s_tlast | input | LINKS | TLAST (control bit) per link |
| s_tready | output | LINKS | TREADY per link |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_we | output | 1 | Destination write strobe for the last operation |
| rd_data | output | DW | Destination word |
| carry | output | 1 | Non-blocking validity carry |
| strm_err | output | 1 | Sticky control-mismatch flag |
| exc | output | 1 | Last operation raised an exception |
| exc_cause | output | 5 | Exception cause code |
| exc_link | output | 4 | Link field of a stream exception |
| exc_data | output | DW | Word captured by a stream exception |
| atomic_hold | output | 1 | Hold off interrupts for the next instruction |

## Verification
The hardest case to reach from the ports is a blocking read stalled on an idle link, hit by a second start pulse with a different index and mode, and then released by TVALID on the selected link alone. The stimulus holds every TVALID low and starts a blocking read on link 2. It lets the unit sit for a few cycles, then pulses start again with a non-blocking command for link 1. That command would complete at once if the unit took it. Finally TVALID is raised on link 2 only, and TREADY is checked in that same cycle and once more after completion. A sweep over every index and every mode combination, run against an instance of each latency configuration, covers the fall-back to link 0 and all the result rules.

// File: rtl/strm_get_pkg.sv
package strm_get_pkg;

  localparam logic [4:0] CAUSE_STREAM = 5'b00000;
  localparam logic [4:0] CAUSE_PRIV   = 5'b00111;

  // latched command: order here fixes the packed concatenation in the top
  typedef struct packed {
    logic [3:0] idx;
    logic       nb;
    logic       ctl;
    logic       exc_en;
    logic       test;
    logic       atom;
    logic       user;
  } cmd_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_HOLD = 2'd2
  } seq_state_t;

endpackage

// File: rtl/sg_link_sel.sv
module sg_link_sel #(
  parameter int LINKS = 4,
  parameter int DW    = 32
) (
  input  logic [3:0]          idx,
  input  logic [LINKS*DW-1:0] tdata,
  input  logic [LINKS-1:0]    tvalid,
  input  logic [LINKS-1:0]    tlast,
  output logic [LINKS-1:0]    onehot,
  output logic                vld,
  output logic                last,
  output logic [DW-1:0]       data
);

  logic in_range;
  assign in_range = (int'(idx) < LINKS);

  // out-of-range index falls back to link 0
  for (genvar g = 0; g < LINKS; g++) begin : g_dec
    assign onehot[g] = in_range ? (int'(idx) == g) : (g == 0);
  end

  always_comb begin
    data = '0;
    for (int k = 0; k < LINKS; k++) begin
      if (onehot[k]) data = data | tdata[k*DW +: DW];
    end
  end

  assign vld  = |(tvalid & onehot);
  assign last = |(tlast & onehot);

endmodule

// File: rtl/sg_seq.sv
module sg_seq
  import strm_get_pkg::*;
#(
  parameter bit AREA_OPT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic go,
  output logic busy,
  output logic acc,
  output logic pub,
  output logic done
);

  seq_state_t st, st_n;

  assign busy = (st != S_IDLE);
  assign acc  = (st == S_WAIT) && go;
  assign pub  = AREA_OPT ? (st == S_HOLD) : acc;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (start) st_n = S_WAIT;
      S_WAIT:  if (go) st_n = AREA_OPT ? S_HOLD : S_IDLE;
      S_HOLD:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_n;
      done <= pub;
    end
  end

endmodule

// File: rtl/sg_result.sv
module sg_result #(
  parameter int DW       = 32,
  parameter bit AREA_OPT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          pub,
  input  logic          err_clr,
  input  logic          i_wr,
  input  logic          i_exc,
  input  logic [4:0]    i_cause,
  input  logic          i_link_upd,
  input  logic [3:0]    i_link,
  input  logic          i_carry_upd,
  input  logic          i_carry,
  input  logic          i_err_set,
  input  logic          i_atom,
  input  logic [DW-1:0] i_data,
  output logic          rd_we,
  output logic [DW-1:0] rd_data,
  output logic          carry,
  output logic          strm_err,
  output logic          exc,
  output logic [4:0]    exc_cause,
  output logic [3:0]    exc_link,
  output logic [DW-1:0] exc_data,
  output logic          atomic_hold
);

  localparam int BW = DW + 16;

  logic [BW-1:0] in_v, st_v;
  logic          s_wr, s_exc, s_lupd, s_cupd, s_cval, s_eset, s_atom;
  logic [4:0]    s_cause;
  logic [3:0]    s_link;
  logic [DW-1:0] s_data;

  assign in_v = {i_wr, i_exc, i_cause, i_link_upd, i_link, i_carry_upd,
                 i_carry, i_err_set, i_atom, i_data};

  if (AREA_OPT) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_v <= '0;
      else if (acc) st_v <= in_v;
    end
  end else begin : g_pass
    assign st_v = in_v;
  end

  assign {s_wr, s_exc, s_cause, s_lupd, s_link, s_cupd,
          s_cval, s_eset, s_atom, s_data} = st_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_we       <= 1'b0;
      rd_data     <= '0;
      carry       <= 1'b0;
      exc         <= 1'b0;
      exc_cause   <= '0;
      exc_link    <= '0;
      exc_data    <= '0;
      atomic_hold <= 1'b0;
    end else if (pub) begin
      rd_we       <= s_wr;
      exc         <= s_exc;
      atomic_hold <= s_atom;
      if (s_wr)   rd_data   <= s_data;
      if (s_exc)  exc_cause <= s_cause;
      if (s_cupd) carry     <= s_cval;
      if (s_lupd) begin
        exc_link <= s_link;
        exc_data <= s_data;
      end
    end
  end

  // sticky flag: a new mismatch wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               strm_err <= 1'b0;
    else if (pub && s_eset)   strm_err <= 1'b1;
    else if (err_clr)         strm_err <= 1'b0;
  end

endmodule

// File: rtl/strm_get_unit.sv
module strm_get_unit
  import strm_get_pkg::*;
#(
  parameter int LINKS    = 4,
  parameter int DW       = 32,
  parameter bit AREA_OPT = 1'b0,
  parameter bit EXC_EN   = 1'b1,
  parameter bit PRIV_EN  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          idx,
  input  logic                mode_n,
  input  logic                mode_c,
  input  logic                mode_e,
  input  logic                mode_t,
  input  logic                mode_a,
  input  logic                user_mode,
  input  logic                err_clr,
  input  logic [LINKS*DW-1:0] s_tdata,
  input  logic [LINKS-1:0]    s_tvalid,
  input  logic [LINKS-1:0]    s_tlast,
  output logic [LINKS-1:0]    s_tready,
  output logic                busy,
  output logic                done,
  output logic                rd_we,
  output logic [DW-1:0]       rd_data,
  output logic                carry,
  output logic                strm_err,
  output logic                exc,
  output logic [4:0]          exc_cause,
  output logic [3:0]          exc_link,
  output logic [DW-1:0]       exc_data,
  output logic                atomic_hold
);

  cmd_t            cmd_q;
  logic [LINKS-1:0] sel_oh;
  logic            sel_vld, sel_last;
  logic [DW-1:0]   sel_data;
  logic            acc, pub, go;
  logic            priv, mism, xc_strm;

  // command is captured only when idle; a start while busy is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cmd_q <= '0;
    else if (start && !busy)  cmd_q <= {idx, mode_n, mode_c, mode_e,
                                        mode_t, mode_a, user_mode};
  end

  sg_link_sel #(.LINKS(LINKS), .DW(DW)) u_sel (
    .idx    (cmd_q.idx),
    .tdata  (s_tdata),
    .tvalid (s_tvalid),
    .tlast  (s_tlast),
    .onehot (sel_oh),
    .vld    (sel_vld),
    .last   (sel_last),
    .data   (sel_data)
  );

  assign priv    = PRIV_EN && cmd_q.user;
  assign go      = priv || cmd_q.nb || sel_vld;
  assign mism    = sel_vld && (sel_last != cmd_q.ctl);
  assign xc_strm = EXC_EN && cmd_q.exc_en && mism && !priv;

  sg_seq #(.AREA_OPT(AREA_OPT)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .go    (go),
    .busy  (busy),
    .acc   (acc),
    .pub   (pub),
    .done  (done)
  );

  assign s_tready = (acc && sel_vld && !cmd_q.test && !priv) ? sel_oh : '0;

  sg_result #(.DW(DW), .AREA_OPT(AREA_OPT)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .pub         (pub),
    .err_clr     (err_clr),
    .i_wr        (!priv && !xc_strm),
    .i_exc       (priv || xc_strm),
    .i_cause     (priv ? CAUSE_PRIV : CAUSE_STREAM),
    .i_link_upd  (xc_strm),
    .i_link      (cmd_q.idx),
    .i_carry_upd (!priv && cmd_q.nb),
    .i_carry     (!sel_vld),
    .i_err_set   (!priv && mism),
    .i_atom      (cmd_q.atom),
    .i_data      (sel_data),
    .rd_we       (rd_we),
    .rd_data     (rd_data),
    .carry       (carry),
    .strm_err    (strm_err),
    .exc         (exc),
    .exc_cause   (exc_cause),
    .exc_link    (exc_link),
    .exc_data    (exc_data),
    .atomic_hold (atomic_hold)
  );

endmodule

// File: rtl/sg_chk.sv
module sg_chk #(
  parameter int LINKS = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             rd_we,
  input logic             exc,
  input logic             strm_err,
  input logic             err_clr,
  input logic [DW-1:0]    rd_data,
  input logic [LINKS-1:0] s_tready,
  input logic [LINKS-1:0] s_tvalid
);

  p_tready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_tready))
    else $error("TREADY raised on more than one link");

  p_tready_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tready & ~s_tvalid) == '0)
    else $error("TREADY on a link without TVALID");

  p_tready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_tready) |-> busy)
    else $error("TREADY while idle");

  p_exc_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> !rd_we)
    else $error("destination written alongside an exception");

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_err && !err_clr) |=> strm_err)
    else $error("stream-error flag dropped without clear");

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data))
    else $error("rd_data moved outside a completion");

endmodule

bind strm_get_unit sg_chk #(.LINKS(LINKS), .DW(DW)) u_sg_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .rd_we    (rd_we),
  .exc      (exc),
  .strm_err (strm_err),
  .err_clr  (err_clr),
  .rd_data  (rd_data),
  .s_tready (s_tready),
  .s_tvalid (s_tvalid)
);

// File: tb/strm_get_unit_bench.sv
module strm_get_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, start, err_clr;
  logic [3:0] idx;
  logic mode_n, mode_c, mode_e, mode_t, mode_a, user_mode;
  logic [NL*W-1:0] tdata;
  logic [NL-1:0] tvalid, tlast;

  logic [NL-1:0] p_tready, a_tready;
  logic p_busy, p_done, p_we, p_carry, p_err, p_exc, p_atom;
  logic a_busy, a_done, a_we, a_carry, a_err, a_exc, a_atom;
  logic [W-1:0] p_rd, p_xd, a_rd, a_xd;
  logic [4:0] p_cause, a_cause;
  logic [3:0] p_link, a_link;

  strm_get_unit #(.LINKS(NL), .DW(W), .AREA_OPT(1'b0)) u_strm_get_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .idx(idx),
    .mode_n(mode_n), .mode_c(mode_c), .mode_e(mode_e), .mode_t(mode_t),
    .mode_a(mode_a), .user_mode(user_mode), .err_clr(err_clr),
    .s_tdata(tdata), .s_tvalid(tvalid), .s_tlast(tlast), .s_tready(p_tready),
    .busy(p_busy), .done(p_done), .rd_we(p_we), .rd_data(p_rd),
    .carry(p_carry), .strm_err(p_err), .exc(p_exc), .exc_cause(p_cause),
    .exc_link(p_link), .exc_data(p_xd), .atomic_hold(p_atom));

  strm_get_unit #(.LINKS(NL), .DW(W), .AREA_OPT(1'b1)) u_strm_get_unit_area (
    .clk(clk), .rst_n(rst_n), .start(start), .idx(idx),
    .mode_n(mode_n), .mode_c(mode_c), .mode_e(mode_e), .mode_t(mode_t),
    .mode_a(mode_a), .user_mode(user_mode), .err_clr(err_clr),
    .s_tdata(tdata), .s_tvalid(tvalid), .s_tlast(tlast), .s_tready(a_tready),
    .busy(a_busy), .done(a_done), .rd_we(a_we), .rd_data(a_rd),
    .carry(a_carry), .strm_err(a_err), .exc(a_exc), .exc_cause(a_cause),
    .exc_link(a_link), .exc_data(a_xd), .atomic_hold(a_atom));

  int checks = 0;
  int fails  = 0;

  logic         m_carry, m_err;
  logic [W-1:0] m_rd, m_xd;
  logic [3:0]   m_link;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] i, input logic nn, cc, ee, tt, aa, uu);
    int sel, l0, l1;
    logic v, lst, priv, mism, xs, we;
    logic [W-1:0] d;
    logic [NL-1:0] etr, tr0, tr1;
    string rq;
    sel  = (int'(i) < NL) ? int'(i) : 0;
    v    = tvalid[sel];
    lst  = tlast[sel];
    d    = tdata[sel*W +: W];
    priv = uu;
    mism = v && (lst != cc);
    xs   = !priv && ee && mism;
    we   = !priv && !xs;
    etr  = (!priv && v && !tt) ? NL'(1 << sel) : '0;
    rq   = tt ? "R6" : (priv ? "R7" : "R1");
    @(negedge clk);
    idx = i; mode_n = nn; mode_c = cc; mode_e = ee; mode_t = tt;
    mode_a = aa; user_mode = uu; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tr0 = p_tready;
    tr1 = a_tready;
    l0 = 0; l1 = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (l0 == 0 && p_done) l0 = k;
      if (l1 == 0 && a_done) l1 = k;
      if (l0 != 0 && l1 != 0) break;
    end
    if (we) m_rd = d;
    if (xs) begin m_link = i; m_xd = d; end
    if (!priv && nn) m_carry = !v;
    if (!priv && mism) m_err = 1'b1;
    chk(tr0 == etr, rq, int'(tr0), int'(etr));
    chk(tr1 == etr, rq, int'(tr1), int'(etr));
    chk(l0 == 1, "R8", l0, 1);
    chk(l1 == 2, "R8", l1, 2);
    chk(p_we == we, "R1", int'(p_we), int'(we));
    chk(p_rd == m_rd, "R1", int'(p_rd), int'(m_rd));
    chk(a_rd == m_rd, "R8", int'(a_rd), int'(m_rd));
    chk(p_carry == m_carry && a_carry == m_carry, "R3", int'(p_carry), int'(m_carry));
    chk(p_exc == (priv || xs) && a_exc == (priv || xs), priv ? "R7" : "R5",
        int'(p_exc), int'(priv || xs));
    if (priv || xs)
      chk(p_cause == (priv ? 5'd7 : 5'd0), priv ? "R7" : "R5", int'(p_cause), priv ? 7 : 0);
    chk(p_link == m_link && p_xd == m_xd, "R5", int'({p_link, p_xd}), int'({m_link, m_xd}));
    chk(p_err == m_err && a_err == m_err, "R4", int'(p_err), int'(m_err));
    chk(p_atom == aa && a_atom == aa, "R9", int'(p_atom), int'(aa));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; err_clr = 1'b0; idx = '0;
    mode_n = 0; mode_c = 0; mode_e = 0; mode_t = 0; mode_a = 0; user_mode = 0;
    tdata = '0; tvalid = '0; tlast = '0;
    m_carry = 0; m_err = 0; m_rd = '0; m_xd = '0; m_link = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!p_busy && !p_done && !a_busy && !a_done, "R11", int'({p_busy, p_done}), 0);
    chk(p_tready == '0 && a_tready == '0, "R11", int'(p_tready), 0);
    chk(p_rd == '0 && !p_we && !p_carry && !p_err && !p_exc && !p_atom, "R11", int'(p_rd), 0);

    // sweep: every index (fall-back to link 0 for 3..15) and mode combination
    tvalid = '1;
    for (int i = 0; i < 16; i++) begin
      for (int m = 0; m < 32; m++) begin
        for (int l = 0; l < NL; l++) tdata[l*W +: W] = W'(i*16 + m*3 + l*85);
        tlast = {NL{m[4]}};
        run_op(4'(i), m[0], m[1], m[2], m[3], 1'(i) ^ m[1], 1'b0);
        if ((i + m) % 5 == 0) begin
          @(negedge clk) err_clr = 1'b1;
          @(negedge clk) err_clr = 1'b0;
          m_err = 1'b0;
          chk(!p_err && !a_err, "R4", int'(p_err), 0);
        end
      end
    end

    // R3 non-blocking on idle links: carry 1, no mismatch reported
    tvalid = '0; tlast = '1;
    for (int i = 0; i < 4; i++) run_op(4'(i), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7 privilege: with idle links (no stall) and with valid mismatching links
    run_op(4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    tvalid = '1;
    for (int i = 0; i < 4; i++) run_op(4'(i), 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

    // R2/R10 stalled blocking read, second start ignored, release on link 2
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    m_err = 1'b0;
    tvalid = '0; tlast = '0; tdata = {8'hC3, 8'h5A, 8'h11};
    @(negedge clk);
    idx = 4'd2; mode_n = 0; mode_c = 0; mode_e = 1; mode_t = 0;
    mode_a = 0; user_mode = 0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chk(p_busy && a_busy && !p_done && !a_done, "R2", int'({p_busy, p_done}), 2);
    chk(p_tready == '0 && a_tready == '0, "R2", int'(p_tready), 0);
    idx = 4'd1; mode_n = 1'b1; start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(p_busy && !p_done, "R10", int'({p_busy, p_done}), 2);
    repeat (2) @(negedge clk);
    chk(!p_done && !a_done, "R10", int'(p_done), 0);
    tvalid = 3'b100;
    #1;
    chk(p_tready == 3'b100, "R2", int'(p_tready), 4);
    chk(a_tready == 3'b100, "R2", int'(a_tready), 4);
    @(negedge clk);
    m_rd = 8'hC3;
    chk(p_done, "R8", int'(p_done), 1);
    chk(p_rd == m_rd, "R10", int'(p_rd), int'(m_rd));
    chk(p_tready == '0, "R2", int'(p_tready), 0);
    chk(p_carry == m_carry, "R3", int'(p_carry), int'(m_carry));
    @(negedge clk);
    chk(a_done && a_rd == m_rd, "R8", int'(a_rd), int'(m_rd));
    chk(a_tready == '0, "R2", int'(a_tready), 0);
    tvalid = '0;
    @(negedge clk);
    chk(!p_done && p_rd == m_rd, "R10", int'(p_rd), int'(m_rd));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule